// File: doc/BRIEF.md
# Receive Frame Descriptor Manager

This block is the receive side of a descriptor-driven network controller. A host prepares, in a shared memory of 16-bit words, a linked chain of frame descriptors and a separate chain of size-limited buffer descriptors. It then pulses channel attention with a command word. Incoming frames arrive one byte per transfer over a ready/valid stream. The final byte carries a last flag and the error flags for the frame. CRC checking and address filtering happen upstream.

For each frame the block claims the next frame descriptor and marks it consumed. It packs bytes little-endian into the current buffer and moves along the buffer chain when a buffer fills. It then writes the buffer and frame status words. It keeps four saturating error counters and reports a frame-received flag, a not-ready flag and the unit state in a status word. Both flags drive `irq`.

The unit state is IDLE, SUSPENDED, NO_RESOURCES or READY. A start command enters READY from any state. Resume goes from SUSPENDED to READY. Suspend goes from READY to SUSPENDED. Abort goes to IDLE from any state. The block leaves READY by itself in three cases: a frame runs out of descriptors (to NO_RESOURCES), a frame completes on a descriptor marked last (to NO_RESOURCES), or a frame completes on a descriptor marked suspend (to SUSPENDED).

The per-frame engine runs WAIT → FD_CMD → FD_LINK → FD_RBD → FD_MARK → RB_NEXT. From RB_NEXT it goes to RB_BUF → RB_SIZE → RB_LOAD → DATA, or to DISCARD when no buffer is left. DATA goes to WR_TAIL when the frame has an odd byte to flush, or straight to RB_CLOSE. RB_CLOSE goes to FD_CLOSE at the end of a frame. Otherwise it goes back to RB_NEXT to take the next buffer, or to DISCARD when the buffer chain has ended. DISCARD goes to FD_CLOSE on the last byte. FD_CLOSE returns to WAIT.

Top module: `rx_fd_manager`

## Requirements
- R1: After reset the status word is 0x0000, all four counters are zero and no memory access is made.
- R2: The command field is `ca_cmd[6:4]` and is sampled while `ca` is high. Its codes are: 0 no-op, 1 start at `rfa_offset`, 2 resume (from suspended only), 3 suspend (from ready only), 4 abort. Codes 5 to 7 act as no-ops. The unit state appears in `scb_status[6:4]` as 0 idle, 1 suspended, 2 no resources, 4 ready.
- R3: `scb_status[14]` is set when a frame descriptor is closed. `scb_status[12]` is set when the engine moves the unit out of ready. A command with bit 14 or bit 12 set clears the matching flag. `irq` is the OR of the two flags.
- R4: A frame descriptor uses word offsets +0 status, +1 command (bit 15 last, bit 14 suspend), +2 link and +3 first-buffer offset. Claiming a descriptor writes 0x4000 to +0. The first descriptor after a start supplies the buffer pointer from +3. Each later descriptor has +3 written with the buffer pointer that the engine hands it.
- R5: The first byte of a buffer goes to the low half of the buffer's first word, so byte k lands in word buf+k/2. An odd final byte is written with a zero high byte.
- R6: A buffer descriptor uses word offsets +0 status, +1 next, +2 buffer word address and +3 size (bit 15 last in list, bits 13:0 capacity in bytes, even). On close its status word becomes {end-of-frame, 1, byte count[13:0]}.
- R7: When a buffer holds its full capacity and another byte of the same frame is pending, the buffer is closed without end-of-frame and the frame continues in the next buffer.
- R8: On a completed frame the descriptor status is: bit 15 set, bit 14 set, bit 13 set only when no error flag is set, bit 11 CRC error, bit 10 alignment error, bit 8 overrun, bit 7 too short.
- R9: Four counters are kept. `crc_errs` counts frames with a CRC error and no alignment error. `aln_errs` counts alignment errors. `ovrn_errs` counts overruns. `rsc_errs` counts frames lost for lack of space. Each counter holds at 0xFFFF.
- R10: A frame with no buffer left has its remaining bytes discarded. Its descriptor status is then 0xC200, `rsc_errs` increments and the unit moves to no resources with the not-ready flag set.
- R11: After a frame on a descriptor marked last, the unit moves to no resources. After a frame on a descriptor marked suspend, it moves to suspended. Both raise the not-ready flag. Otherwise the next frame uses the link.
- R12: Outside ready, bytes are accepted and dropped with no memory write. In the no-resources state each dropped frame increments `rsc_errs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ca | input | 1 | Channel attention pulse |
| ca_cmd | input | 16 | Command word sampled with `ca` |
| rfa_offset | input | AW | First frame descriptor for a start |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after the request |
| rx_valid | input | 1 | Byte available |
| rx_byte | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of frame |
| rx_crc_err | input | 1 | CRC error, with last byte |
| rx_align_err | input | 1 | Alignment error, with last byte |
| rx_overrun | input | 1 | Overrun, with last byte |
| rx_short | input | 1 | Frame too short, with last byte |
| rx_ready | output | 1 | Byte taken at this edge |
| scb_status | output | 16 | Flags and unit state |
| irq | output | 1 | Interrupt request |
| crc_errs | output | CNT_W | CRC error counter |
| aln_errs | output | CNT_W | Alignment error counter |
| rsc_errs | output | CNT_W | Lost-for-space counter |
| ovrn_errs | output | CNT_W | Overrun counter |

## Verification
The assertions assume that memory returns read data exactly one cycle after each request, that error flags are meaningful only with the last byte, and that buffer capacities are even. They also assume that a start command never coincides with a frame being stored or with the close of a descriptor. The bench models memory with a fixed one-cycle read. It presents errors only on final bytes and uses even capacities. It issues commands only after the engine has gone quiet following each frame, so the state checks see commands and engine events in separate cycles.

// File: rtl/rxfd_pkg.sv
package rxfd_pkg;

    typedef enum logic [2:0] {
        RUS_IDLE  = 3'd0,
        RUS_SUSP  = 3'd1,
        RUS_NRES  = 3'd2,
        RUS_READY = 3'd4
    } rus_e;

    typedef enum logic [3:0] {
        E_WAIT, E_FD_CMD, E_FD_LINK, E_FD_RBD, E_FD_MARK,
        E_RB_NEXT, E_RB_BUF, E_RB_SIZE, E_RB_LOAD, E_DATA,
        E_WR_TAIL, E_RB_CLOSE, E_DISCARD, E_FD_CLOSE
    } eng_e;

    typedef struct packed {
        logic start;
        logic resume;
        logic suspend;
        logic abort;
        logic ack_fr;
        logic ack_rnr;
    } cmd_t;

    typedef struct packed {
        logic close;
        logic nores;
        logic last_fd;
        logic susp_fd;
        logic crc;
        logic aln;
        logic ovr;
        logic drop_lost;
    } ev_t;

    localparam int RUC_LSB    = 4;
    localparam int ACK_FR_BIT = 14;
    localparam int ACK_RN_BIT = 12;

endpackage

// File: rtl/rxfd_cmd_decode.sv
module rxfd_cmd_decode
    import rxfd_pkg::*;
(
    input  logic        ca,
    input  logic [15:0] cmd_word,
    output cmd_t        dec
);
    logic [2:0] ruc;
    assign ruc = cmd_word[RUC_LSB +: 3];

    always_comb begin
        dec = '0;
        if (ca) begin
            dec.ack_fr  = cmd_word[ACK_FR_BIT];
            dec.ack_rnr = cmd_word[ACK_RN_BIT];
            case (ruc)
                3'd1:    dec.start   = 1'b1;
                3'd2:    dec.resume  = 1'b1;
                3'd3:    dec.suspend = 1'b1;
                3'd4:    dec.abort   = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxfd_sat_counter.sv
module rxfd_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               q <= '0;
        else if (inc && q != TOP) q <= q + 1'b1;
    end

    assert_hold_at_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q == TOP |=> q == TOP);
    assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(q));
endmodule

// File: rtl/rxfd_engine.sv
module rxfd_engine
    import rxfd_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CAP_W = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          unit_ready,
    input  logic          unit_nores,
    input  logic          start,
    input  logic [AW-1:0] start_fd,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          rx_last,
    input  logic          rx_crc_err,
    input  logic          rx_align_err,
    input  logic          rx_overrun,
    input  logic          rx_short,
    output logic          rx_ready,
    output ev_t           ev
);
    localparam logic [AW-1:0] NULL_PTR = {AW{1'b1}};
    localparam int            PAD_W    = 16 - CAP_W - 2;

    eng_e              state, nstate;
    logic [AW-1:0]     fd_ptr, fd_link, rbd_ptr, rb_next, rb_buf;
    logic [CAP_W-1:0]  rb_cap, cnt;
    logic              fd_el, fd_s, rb_last, need_load, in_drop;
    logic              eof, nores, e_crc, e_aln, e_ovr, e_short;
    logic [7:0]        low_byte;
    logic              accept;
    logic [AW-1:0]     word_off;
    logic              frame_ok;

    assign word_off = AW'(cnt >> 1);
    assign frame_ok = !nores && !(e_crc || e_aln || e_ovr || e_short);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= E_WAIT;
        else        state <= nstate;
    end

    // next state and outputs
    always_comb begin
        nstate    = state;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rx_ready  = 1'b0;
        accept    = 1'b0;
        ev        = '0;
        unique case (state)
            E_WAIT: begin
                if (in_drop || !unit_ready) begin
                    rx_ready     = 1'b1;
                    ev.drop_lost = rx_valid && rx_last && unit_nores;
                end else if (rx_valid) begin
                    nstate = E_FD_CMD;
                end
            end
            E_FD_CMD: begin
                mem_req  = 1'b1;
                mem_addr = fd_ptr + AW'(1);
                nstate   = E_FD_LINK;
            end
            E_FD_LINK: begin
                mem_req  = 1'b1;
                mem_addr = fd_ptr + AW'(2);
                nstate   = E_FD_RBD;
            end
            E_FD_RBD: begin
                mem_req   = 1'b1;
                mem_we    = !need_load;
                mem_addr  = fd_ptr + AW'(3);
                mem_wdata = 16'(rbd_ptr);
                nstate    = E_FD_MARK;
            end
            E_FD_MARK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = fd_ptr;
                mem_wdata = 16'h4000;
                nstate    = E_RB_NEXT;
            end
            E_RB_NEXT: begin
                if (rbd_ptr == NULL_PTR) begin
                    nstate = E_DISCARD;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = rbd_ptr + AW'(1);
                    nstate   = E_RB_BUF;
                end
            end
            E_RB_BUF: begin
                mem_req  = 1'b1;
                mem_addr = rbd_ptr + AW'(2);
                nstate   = E_RB_SIZE;
            end
            E_RB_SIZE: begin
                mem_req  = 1'b1;
                mem_addr = rbd_ptr + AW'(3);
                nstate   = E_RB_LOAD;
            end
            E_RB_LOAD: nstate = E_DATA;
            E_DATA: begin
                if (rx_valid) begin
                    if (cnt == rb_cap) begin
                        nstate = E_RB_CLOSE;
                    end else begin
                        rx_ready = 1'b1;
                        accept   = 1'b1;
                        if (cnt[0]) begin
                            mem_req   = 1'b1;
                            mem_we    = 1'b1;
                            mem_addr  = rb_buf + word_off;
                            mem_wdata = {rx_byte, low_byte};
                        end
                        if (rx_last) nstate = cnt[0] ? E_RB_CLOSE : E_WR_TAIL;
                    end
                end
            end
            E_WR_TAIL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rb_buf + word_off;
                mem_wdata = {8'h00, low_byte};
                nstate    = E_RB_CLOSE;
            end
            E_RB_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rbd_ptr;
                mem_wdata = {eof, 1'b1, {PAD_W{1'b0}}, cnt};
                if (eof)          nstate = E_FD_CLOSE;
                else if (rb_last) nstate = E_DISCARD;
                else              nstate = E_RB_NEXT;
            end
            E_DISCARD: begin
                rx_ready = 1'b1;
                if (rx_valid && rx_last) nstate = E_FD_CLOSE;
            end
            E_FD_CLOSE: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                mem_addr   = fd_ptr;
                mem_wdata  = {1'b1, 1'b1, frame_ok, 1'b0, e_crc, e_aln,
                              nores, e_ovr, e_short, 7'b0};
                ev.close   = 1'b1;
                ev.nores   = nores;
                ev.last_fd = fd_el;
                ev.susp_fd = fd_s;
                ev.crc     = e_crc;
                ev.aln     = e_aln;
                ev.ovr     = e_ovr;
                nstate     = E_WAIT;
            end
            default: nstate = E_WAIT;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fd_ptr <= '0; fd_link <= '0; rbd_ptr <= NULL_PTR; rb_next <= '0;
            rb_buf <= '0; rb_cap <= '0; cnt <= '0; fd_el <= 1'b0; fd_s <= 1'b0;
            rb_last <= 1'b0; need_load <= 1'b0; in_drop <= 1'b0; eof <= 1'b0;
            nores <= 1'b0; e_crc <= 1'b0; e_aln <= 1'b0; e_ovr <= 1'b0;
            e_short <= 1'b0; low_byte <= '0;
        end else begin
            unique case (state)
                E_WAIT: begin
                    if (rx_ready && rx_valid) in_drop <= !rx_last;
                    if (!in_drop && unit_ready && rx_valid) begin
                        nores <= 1'b0; eof <= 1'b0;
                        e_crc <= 1'b0; e_aln <= 1'b0; e_ovr <= 1'b0; e_short <= 1'b0;
                    end
                end
                E_FD_LINK: begin
                    fd_el <= mem_rdata[15];
                    fd_s  <= mem_rdata[14];
                end
                E_FD_RBD:  fd_link <= mem_rdata[AW-1:0];
                E_FD_MARK: begin
                    if (need_load) rbd_ptr <= mem_rdata[AW-1:0];
                    need_load <= 1'b0;
                end
                E_RB_NEXT: if (rbd_ptr == NULL_PTR) nores <= 1'b1;
                E_RB_BUF:  rb_next <= mem_rdata[AW-1:0];
                E_RB_SIZE: rb_buf  <= mem_rdata[AW-1:0];
                E_RB_LOAD: begin
                    rb_cap  <= mem_rdata[CAP_W-1:0];
                    rb_last <= mem_rdata[15];
                    cnt     <= '0;
                end
                E_DATA: begin
                    if (accept) begin
                        cnt <= cnt + 1'b1;
                        if (!cnt[0]) low_byte <= rx_byte;
                        if (rx_last) begin
                            eof     <= 1'b1;
                            e_crc   <= rx_crc_err;
                            e_aln   <= rx_align_err;
                            e_ovr   <= rx_overrun;
                            e_short <= rx_short;
                        end
                    end
                end
                E_RB_CLOSE: begin
                    if (eof)          rbd_ptr <= rb_last ? NULL_PTR : rb_next;
                    else if (rb_last) nores   <= 1'b1;
                    else              rbd_ptr <= rb_next;
                end
                E_FD_CLOSE: fd_ptr <= fd_link;
                default: ;
            endcase
            if (start) begin
                fd_ptr    <= start_fd;
                need_load <= 1'b1;
            end
        end
    end

    assert_cnt_within_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state == E_DATA |-> cnt <= rb_cap);
    assert_store_only_when_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == E_WAIT) |-> !mem_req);
    assert_write_is_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);
    assert_close_after_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == E_WR_TAIL |=> state == E_RB_CLOSE);
endmodule

// File: rtl/rx_fd_manager.sv
module rx_fd_manager
    import rxfd_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CNT_W = 16,
    parameter int CAP_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ca,
    input  logic [15:0]      ca_cmd,
    input  logic [AW-1:0]    rfa_offset,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_last,
    input  logic             rx_crc_err,
    input  logic             rx_align_err,
    input  logic             rx_overrun,
    input  logic             rx_short,
    output logic             rx_ready,
    output logic [15:0]      scb_status,
    output logic             irq,
    output logic [CNT_W-1:0] crc_errs,
    output logic [CNT_W-1:0] aln_errs,
    output logic [CNT_W-1:0] rsc_errs,
    output logic [CNT_W-1:0] ovrn_errs
);
    localparam int NCNT = 4;

    rus_e rus, rus_nxt;
    logic fr, fr_nxt, rnr, rnr_nxt, leave_ready, cmd_any;
    cmd_t dec;
    ev_t  ev;

    rxfd_cmd_decode u_dec (
        .ca       (ca),
        .cmd_word (ca_cmd),
        .dec      (dec)
    );

    rxfd_engine #(.AW(AW), .CAP_W(CAP_W)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .unit_ready   (rus == RUS_READY),
        .unit_nores   (rus == RUS_NRES),
        .start        (dec.start),
        .start_fd     (rfa_offset),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .rx_last      (rx_last),
        .rx_crc_err   (rx_crc_err),
        .rx_align_err (rx_align_err),
        .rx_overrun   (rx_overrun),
        .rx_short     (rx_short),
        .rx_ready     (rx_ready),
        .ev           (ev)
    );

    assign cmd_any = dec.start || dec.resume || dec.suspend || dec.abort;

    // unit state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rus <= RUS_IDLE;
            fr  <= 1'b0;
            rnr <= 1'b0;
        end else begin
            rus <= rus_nxt;
            fr  <= fr_nxt;
            rnr <= rnr_nxt;
        end
    end

    // unit transitions and flags
    always_comb begin
        rus_nxt     = rus;
        leave_ready = 1'b0;
        if (dec.start) begin
            rus_nxt = RUS_READY;
        end else if (dec.resume) begin
            if (rus == RUS_SUSP) rus_nxt = RUS_READY;
        end else if (dec.suspend) begin
            if (rus == RUS_READY) rus_nxt = RUS_SUSP;
        end else if (dec.abort) begin
            rus_nxt = RUS_IDLE;
        end else if (ev.close && rus == RUS_READY) begin
            if (ev.nores || ev.last_fd) begin
                rus_nxt     = RUS_NRES;
                leave_ready = 1'b1;
            end else if (ev.susp_fd) begin
                rus_nxt     = RUS_SUSP;
                leave_ready = 1'b1;
            end
        end
        fr_nxt  = ev.close    ? 1'b1 : (dec.ack_fr  ? 1'b0 : fr);
        rnr_nxt = leave_ready ? 1'b1 : (dec.ack_rnr ? 1'b0 : rnr);
    end

    assign scb_status = {1'b0, fr, 1'b0, rnr, 5'b0, rus, 4'b0};
    assign irq        = fr || rnr;

    // error counters: 0 crc, 1 alignment, 2 no space, 3 overrun
    logic [NCNT-1:0]  inc;
    logic [CNT_W-1:0] cq [NCNT];

    assign inc[0] = ev.close && ev.crc && !ev.aln;
    assign inc[1] = ev.close && ev.aln;
    assign inc[2] = (ev.close && ev.nores) || ev.drop_lost;
    assign inc[3] = ev.close && ev.ovr;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        rxfd_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[g]),
            .q     (cq[g])
        );
    end

    assign crc_errs  = cq[0];
    assign aln_errs  = cq[1];
    assign rsc_errs  = cq[2];
    assign ovrn_errs = cq[3];

    assert_rus_encoding_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scb_status[6:4] inside {3'd0, 3'd1, 3'd2, 3'd4});
    assert_fr_from_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scb_status[14]) |-> $past(ev.close));
    assert_nores_moves_unit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev.close && ev.nores && !cmd_any && rus == RUS_READY
        |=> scb_status[6:4] == 3'd2 && scb_status[12]);
    assert_last_fd_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev.close && ev.last_fd && !cmd_any && rus == RUS_READY
        |=> scb_status[6:4] == 3'd2 && scb_status[12]);
    assert_susp_fd_pauses_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev.close && ev.susp_fd && !ev.last_fd && !ev.nores && !cmd_any && rus == RUS_READY
        |=> scb_status[6:4] == 3'd1 && scb_status[12]);
endmodule

// File: tb/rx_fd_manager_tb.sv
`timescale 1ns/1ps
module rx_fd_manager_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ca = 1'b0;
    logic [15:0] ca_cmd = '0;
    logic [15:0] rfa_offset = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_crc_err = 1'b0, rx_align_err = 1'b0, rx_overrun = 1'b0, rx_short = 1'b0;
    logic        rx_ready, irq;
    logic [15:0] scb_status, crc_errs, aln_errs, rsc_errs, ovrn_errs;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] mem [0:4095];

    always #2.5 clk = ~clk;

    rx_fd_manager u_dut (
        .clk(clk), .rst_n(rst_n), .ca(ca), .ca_cmd(ca_cmd), .rfa_offset(rfa_offset),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
        .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err),
        .rx_overrun(rx_overrun), .rx_short(rx_short), .rx_ready(rx_ready),
        .scb_status(scb_status), .irq(irq), .crc_errs(crc_errs),
        .aln_errs(aln_errs), .rsc_errs(rsc_errs), .ovrn_errs(ovrn_errs)
    );

    // word memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:0]];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic command(input logic [15:0] c, input logic [15:0] rfa);
        ca = 1'b1; ca_cmd = c; rfa_offset = rfa;
        @(negedge clk);
        ca = 1'b0; ca_cmd = '0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic last, input logic [3:0] errs);
        rx_valid = 1'b1; rx_byte = b; rx_last = last;
        {rx_crc_err, rx_align_err, rx_overrun, rx_short} = last ? errs : 4'b0;
        #0.5;
        while (!rx_ready) begin
            @(negedge clk);
            #0.5;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        {rx_crc_err, rx_align_err, rx_overrun, rx_short} = 4'b0;
    endtask

    // errs order: crc, alignment, overrun, short
    task automatic send_frame(input int n, input logic [7:0] seed, input logic [3:0] errs);
        for (int i = 0; i < n; i++) send_byte(seed + 8'(i), i == n - 1, errs);
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 status", {16'h0, scb_status}, 32'h0);
        chk("R1 counters", {crc_errs, aln_errs | rsc_errs | ovrn_errs}, 32'h0);
        chk("R1 no access", {31'h0, mem_req}, 32'h0);
        chk("R3 irq idle", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_chain_and_crc();
        mem[16'h100] = 16'h0000; mem[16'h101] = 16'h0000; mem[16'h102] = 16'h0110; mem[16'h103] = 16'h0200;
        mem[16'h111] = 16'h0000; mem[16'h112] = 16'h0120; mem[16'h113] = 16'h0000;
        mem[16'h121] = 16'h8000; mem[16'h122] = 16'h0130;
        mem[16'h201] = 16'h0210; mem[16'h202] = 16'h0400; mem[16'h203] = 16'h0008;
        mem[16'h211] = 16'h0220; mem[16'h212] = 16'h0410; mem[16'h213] = 16'h0008;
        mem[16'h221] = 16'h0230; mem[16'h222] = 16'h0420; mem[16'h223] = 16'h0008;
        mem[16'h231] = 16'hFFFF; mem[16'h232] = 16'h0430; mem[16'h233] = 16'h8010;
        command(16'h0010, 16'h0100);
        chk("R2 start ready", {16'h0, scb_status}, 32'h0040);
        send_frame(5, 8'h10, 4'b0000);
        chk("R5 word0", {16'h0, mem[16'h400]}, 32'h1110);
        chk("R5 word1", {16'h0, mem[16'h401]}, 32'h1312);
        chk("R5 odd tail", {16'h0, mem[16'h402]}, 32'h0014);
        chk("R6 rbd eof", {16'h0, mem[16'h200]}, 32'hC005);
        chk("R8 fd ok", {16'h0, mem[16'h100]}, 32'hE000);
        chk("R3 fr set", {16'h0, scb_status}, 32'h4040);
        chk("R3 irq", {31'h0, irq}, 32'h1);
        send_frame(10, 8'h20, 4'b1000);
        chk("R4 rbd handed on", {16'h0, mem[16'h113]}, 32'h0210);
        chk("R7 full buffer", {16'h0, mem[16'h210]}, 32'h4008);
        chk("R7 last word first buf", {16'h0, mem[16'h413]}, 32'h2726);
        chk("R7 next buffer data", {16'h0, mem[16'h420]}, 32'h2928);
        chk("R6 second rbd", {16'h0, mem[16'h220]}, 32'hC002);
        chk("R8 fd crc", {16'h0, mem[16'h110]}, 32'hC800);
        chk("R9 crc count", {16'h0, crc_errs}, 32'h1);
        command(16'h5000, 16'h0);
        chk("R3 ack clears", {16'h0, scb_status}, 32'h0040);
    endtask

    task automatic t_last_fd();
        send_frame(3, 8'h30, 4'b1101);
        chk("R5 tail data", {16'h0, mem[16'h431]}, 32'h0032);
        chk("R8 fd errs", {16'h0, mem[16'h120]}, 32'hCC80);
        chk("R9 align count", {16'h0, aln_errs}, 32'h1);
        chk("R9 crc not on align", {16'h0, crc_errs}, 32'h1);
        chk("R11 last fd nores", {16'h0, scb_status}, 32'h5020);
        send_frame(2, 8'h38, 4'b0000);
        chk("R12 nores drop counted", {16'h0, rsc_errs}, 32'h1);
        chk("R12 no store", {16'h0, mem[16'h432]}, 32'h0000);
    endtask

    task automatic t_suspend_and_nores();
        mem[16'h141] = 16'h4000; mem[16'h142] = 16'h0150; mem[16'h143] = 16'h0240;
        mem[16'h151] = 16'h0000; mem[16'h152] = 16'h0160;
        mem[16'h241] = 16'h0250; mem[16'h242] = 16'h0440; mem[16'h243] = 16'h0004;
        mem[16'h251] = 16'hFFFF; mem[16'h252] = 16'h0450; mem[16'h253] = 16'h8004;
        command(16'h5010, 16'h0140);
        send_frame(2, 8'h40, 4'b0010);
        chk("R5 even end", {16'h0, mem[16'h440]}, 32'h4140);
        chk("R8 fd overrun", {16'h0, mem[16'h140]}, 32'hC100);
        chk("R9 overrun count", {16'h0, ovrn_errs}, 32'h1);
        chk("R11 suspend bit", {16'h0, scb_status}, 32'h5010);
        send_frame(1, 8'h48, 4'b0000);
        chk("R12 suspended drop not counted", {16'h0, rsc_errs}, 32'h1);
        command(16'h5020, 16'h0);
        chk("R2 resume", {16'h0, scb_status}, 32'h0040);
        send_frame(6, 8'h50, 4'b0000);
        chk("R4 fd rbd write", {16'h0, mem[16'h153]}, 32'h0250);
        chk("R7 partial list", {16'h0, mem[16'h451]}, 32'h5352);
        chk("R10 rbd no eof", {16'h0, mem[16'h250]}, 32'h4004);
        chk("R10 fd status", {16'h0, mem[16'h150]}, 32'hC200);
        chk("R10 rsc count", {16'h0, rsc_errs}, 32'h2);
        chk("R10 unit nores", {16'h0, scb_status}, 32'h5020);
    endtask

    task automatic t_commands();
        mem[16'h171] = 16'h0000; mem[16'h172] = 16'h0170; mem[16'h173] = 16'hFFFF;
        command(16'h0020, 16'h0);
        chk("R2 resume ignored in nores", {16'h0, scb_status}, 32'h5020);
        command(16'h5010, 16'h0170);
        command(16'h0030, 16'h0);
        chk("R2 suspend", {16'h0, scb_status}, 32'h0010);
        command(16'h0050, 16'h0);
        chk("R2 code5 no-op", {16'h0, scb_status}, 32'h0010);
        command(16'h0020, 16'h0);
        chk("R2 resume from susp", {16'h0, scb_status}, 32'h0040);
        command(16'h0040, 16'h0);
        chk("R2 abort idle", {16'h0, scb_status}, 32'h0000);
        send_frame(2, 8'h58, 4'b0000);
        chk("R12 idle drop not counted", {16'h0, rsc_errs}, 32'h2);
    endtask

    task automatic t_no_buffer_and_saturate();
        command(16'h0010, 16'h0170);
        send_frame(1, 8'h60, 4'b0000);
        chk("R10 null rbd fd", {16'h0, mem[16'h170]}, 32'hC200);
        chk("R10 null rbd count", {16'h0, rsc_errs}, 32'h3);
        chk("R10 null rbd state", {16'h0, scb_status}, 32'h5020);
        rx_valid = 1'b1; rx_last = 1'b1; rx_byte = 8'h77;
        for (int i = 0; i < 65540; i++) @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 saturate", {16'h0, rsc_errs}, 32'hFFFF);
        chk("R9 others held", {16'h0, ovrn_errs}, 32'h1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chain_and_crc();
        t_last_fd();
        t_suspend_and_nores();
        t_commands();
        t_no_buffer_and_saturate();
        summary();
        $finish;
    end
endmodule